// File: doc/BRIEF.md
# Masked-Write Control Register Bank for a Four-Lane Display PHY

This block holds the static configuration of a four-lane serial display transmitter and its auxiliary channel: lane idle and power-down controls, PLL power-down, divider and rate selection, per-lane drive amplitude, emphasis and amplitude scale, spread-spectrum settings and the auxiliary channel's power and bias controls. Software reaches it over a plain 32-bit register bus with a write strobe, a read strobe and a byte address. Every decoded field is driven straight from its storage flop to the PHY.

Each bus write carries its own bit-enable mask: the upper half-word of the write data selects which bits of the lower half-word land in the addressed 16-bit register. A driver can change one lane's emphasis, or drop the PLL power-down, in one write without first reading the register. A status word returns the PLL-ready indication. Writes to status or unmapped locations are dropped, and reads of unmapped locations return zero.

Top module: `phyreg_bank`

## Requirements
- R1: On a write to a control register, each of its 16 bits whose enable bit (write data bit n+16 for data bit n) is set takes data bit n on the clock edge, and every bit whose enable is clear keeps its value; an all-zero mask changes nothing.
- R2: Twelve 16-bit control registers sit at byte offsets 0x00 to 0x2C, register k at offset 4*k; all 16 bits of each one are storage and read back as written.
- R3: After reset, register 0x00 reads 0x0FF1 (all lane idle bits, all lane power-down bits and PLL power-down set) and every other control register reads 0x0000.
- R4: The field outputs follow the stored bits from the edge that writes them: 0x00 gives lane idle [11:8], lane power-down [7:4], IDDQ enable [1], PLL power-down [0]; 0x04 gives the PLL divider [14:0]; 0x08 gives termination [10:8], rate [5:4], reference divider [3:0]; 0x0C gives a 4-bit emphasis per lane, lane n at [4n+3:4n]; 0x10 gives a 3-bit amplitude per lane, lane n at [4n+2:4n]; 0x14 gives transmit mode [9:8] and a 2-bit scale per lane at [2n+1:2n]; 0x18 gives spread depth [15:12], spread enable [11], spread step [9:0]; 0x1C, 0x20 and 0x24 appear whole; 0x28 gives auxiliary receiver power-down select [5], driver power-down select [4], idle [2], receiver power-down [1], driver power-down [0]; 0x2C gives auxiliary common mode [14:12], mode [11:10], amplitude scale [9:8], amplitude [6:4], termination [2:0].
- R5: A read of offset 0x30 returns the PLL-ready input, sampled at the read edge, in bit 0 with all other bits zero; a read of 0x34 returns zero.
- R6: Writes to 0x30, 0x34, any offset at or above 0x30, or any offset whose two low bits are not zero leave every control register and every field output unchanged.
- R7: Read data appears on the clock edge that samples the read strobe and holds until the next read; its upper half-word is always zero, and reads of unmapped or misaligned offsets return zero.
- R8: When a read and a write address the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data; [31:16] bit enables, [15:0] value |
| rdata | output | 32 | Registered read data |
| pll_ready | input | 1 | PLL lock indication from the PHY |
| lane_idle | output | 4 | Per-lane transmit idle |
| lane_pwrdn | output | 4 | Per-lane transmit power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pwrdn | output | 1 | PLL power-down |
| pll_div | output | 15 | PLL feedback divider |
| ref_div | output | 4 | Reference divider |
| rate_sel | output | 2 | Link rate select |
| tx_term | output | 3 | Transmit termination trim |
| lane_emph | output | 16 | Per-lane emphasis, 4 bits per lane |
| lane_amp | output | 12 | Per-lane amplitude, 3 bits per lane |
| lane_amp_scale | output | 8 | Per-lane amplitude scale, 2 bits per lane |
| tx_mode | output | 2 | Transmit mode |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_step | output | 10 | Spread-spectrum step count |
| spare_ctl | output | 16 | Spare control word |
| pll_ctl | output | 16 | PLL trim word |
| tx_ctl | output | 16 | Transmitter trim word |
| aux_rcv_pd_sel | output | 1 | Auxiliary receiver power-down source select |
| aux_drv_pd_sel | output | 1 | Auxiliary driver power-down source select |
| aux_idle | output | 1 | Auxiliary channel idle |
| aux_rcv_pd | output | 1 | Auxiliary receiver power-down |
| aux_drv_pd | output | 1 | Auxiliary driver power-down |
| aux_vcm | output | 3 | Auxiliary receiver common-mode trim |
| aux_mode | output | 2 | Auxiliary channel mode |
| aux_amp_scale | output | 2 | Auxiliary amplitude scale |
| aux_amp | output | 3 | Auxiliary amplitude |
| aux_rterm | output | 3 | Auxiliary termination trim |

## Verification
Masked writes are tried with a full mask, a single-nibble mask, a mask covering only the lane idle bits and an all-zero mask, which separates a design that honours the enables from one that writes whole words or ignores the data. Distinct per-register patterns written to every offset and read back show that address decode and read selection pick the right register and that field outputs come from the right bit positions. Writes to status, out-of-range and misaligned offsets, a read racing a write to one register, and status reads with the PLL-ready input low and then high tell apart decode leaks, read-before-write ordering and a stale or constant status bit.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

   localparam int REG_W     = 16;
   localparam int BUS_W     = 32;
   localparam int ADDR_W    = 8;
   localparam int NUM_CTRL  = 12;
   localparam int NUM_LANES = 4;
   localparam int IDX_W     = $clog2(NUM_CTRL);

   localparam logic [ADDR_W-1:0] STAT0_OFF = ADDR_W'(NUM_CTRL * 4);

   // register slots; the PHY decodes fields by these positions
   localparam int IX_PWR    = 0;
   localparam int IX_PLLDIV = 1;
   localparam int IX_CLK    = 2;
   localparam int IX_EMPH   = 3;
   localparam int IX_AMP    = 4;
   localparam int IX_SCALE  = 5;
   localparam int IX_SSC    = 6;
   localparam int IX_SPARE  = 7;
   localparam int IX_PLLCTL = 8;
   localparam int IX_TXCTL  = 9;
   localparam int IX_AUXPWR = 10;
   localparam int IX_AUXCFG = 11;

   // power-safe reset image: lanes idle and powered down, PLL off
   function automatic logic [REG_W-1:0] ctl_reset(input int idx);
      logic [REG_W-1:0] v;
      v = '0;
      if (idx == IX_PWR) begin
         v[8 +: NUM_LANES] = '1;
         v[4 +: NUM_LANES] = '1;
         v[0]              = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/phyreg_addr_dec.sv
module phyreg_addr_dec #(
   parameter int                ADDR_W   = 8,
   parameter int                NUM_CTRL = 12,
   parameter int                IDX_W    = 4,
   parameter logic [ADDR_W-1:0] STAT0    = 8'h30
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ctrl_hit,
   output logic [IDX_W-1:0]  ctrl_idx,
   output logic              stat0_hit
);

   logic aligned;

   assign aligned   = (addr[1:0] == 2'b00);
   assign ctrl_hit  = aligned && (32'(addr[ADDR_W-1:2]) < NUM_CTRL);
   assign ctrl_idx  = addr[2 +: IDX_W];
   assign stat0_hit = (addr == STAT0);

endmodule

// File: rtl/phyreg_wmask_cell.sv
module phyreg_wmask_cell #(
   parameter int           W   = 16,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] data,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else if (we) q <= (q & ~mask) | (data & mask);
   end

   // R1
   keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q ^ $past(q)) & ~$past(mask)) == '0);

   // R1
   take_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q ^ $past(data)) & $past(mask)) == '0);

   // R6
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/phyreg_rd_mux.sv
module phyreg_rd_mux #(
   parameter int REG_W     = 16,
   parameter int BUS_W     = 32,
   parameter int NUM_CTRL  = 12,
   parameter int IDX_W     = 4,
   parameter bit READ_FLOP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  logic                      ctrl_hit,
   input  logic [IDX_W-1:0]          ctrl_idx,
   input  logic                      stat0_hit,
   input  logic [NUM_CTRL*REG_W-1:0] ctrl_flat,
   input  logic                      pll_ready,
   output logic [BUS_W-1:0]          rdata
);

   logic [REG_W-1:0] sel_word;
   logic [BUS_W-1:0] rd_val;

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < NUM_CTRL; i++) begin
         if (ctrl_idx == IDX_W'(i)) sel_word = ctrl_flat[i*REG_W +: REG_W];
      end
   end

   always_comb begin
      if (ctrl_hit)       rd_val = BUS_W'(sel_word);
      else if (stat0_hit) rd_val = BUS_W'(pll_ready);
      else                rd_val = '0;
   end

   generate
      if (READ_FLOP) begin : g_flop
         logic [BUS_W-1:0] rdata_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= rd_val;
         end
         assign rdata = rdata_q;

         // R5
         stat_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && stat0_hit) |=> rdata == BUS_W'($past(pll_ready)));

         // R7
         upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> rdata[BUS_W-1:REG_W] == '0);

         // R7
         unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !ctrl_hit && !stat0_hit) |=> rdata == '0);

         // R7
         rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rdata));
      end else begin : g_comb
         assign rdata = rd_val;
      end
   endgenerate

endmodule

// File: rtl/phyreg_bank.sv
module phyreg_bank
   import phyreg_pkg::*;
#(
   parameter int  P_ADDR_W    = phyreg_pkg::ADDR_W,
   parameter int  P_BUS_W     = phyreg_pkg::BUS_W,
   parameter int  P_REG_W     = phyreg_pkg::REG_W,
   parameter int  P_NUM_LANES = phyreg_pkg::NUM_LANES,
   parameter bit  READ_FLOP   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [P_ADDR_W-1:0]        addr,
   input  logic [P_BUS_W-1:0]         wdata,
   output logic [P_BUS_W-1:0]         rdata,
   input  logic                       pll_ready,
   output logic [P_NUM_LANES-1:0]     lane_idle,
   output logic [P_NUM_LANES-1:0]     lane_pwrdn,
   output logic                       iddq_en,
   output logic                       pll_pwrdn,
   output logic [14:0]                pll_div,
   output logic [3:0]                 ref_div,
   output logic [1:0]                 rate_sel,
   output logic [2:0]                 tx_term,
   output logic [4*P_NUM_LANES-1:0]   lane_emph,
   output logic [3*P_NUM_LANES-1:0]   lane_amp,
   output logic [2*P_NUM_LANES-1:0]   lane_amp_scale,
   output logic [1:0]                 tx_mode,
   output logic [3:0]                 ssc_depth,
   output logic                       ssc_en,
   output logic [9:0]                 ssc_step,
   output logic [15:0]                spare_ctl,
   output logic [15:0]                pll_ctl,
   output logic [15:0]                tx_ctl,
   output logic                       aux_rcv_pd_sel,
   output logic                       aux_drv_pd_sel,
   output logic                       aux_idle,
   output logic                       aux_rcv_pd,
   output logic                       aux_drv_pd,
   output logic [2:0]                 aux_vcm,
   output logic [1:0]                 aux_mode,
   output logic [1:0]                 aux_amp_scale,
   output logic [2:0]                 aux_amp,
   output logic [2:0]                 aux_rterm
);

   localparam int FLAT_W = NUM_CTRL * P_REG_W;

   // elaboration-time parameter checks
   generate
      if (P_BUS_W != 2 * P_REG_W) begin : g_bad_bus
         $error("bus width must hold a mask half-word and a data half-word");
      end
      if (P_NUM_LANES < 1 || P_NUM_LANES > 4) begin : g_bad_lanes
         $error("lane fields are laid out for one to four lanes");
      end
      if (P_REG_W != REG_W || P_ADDR_W != ADDR_W) begin : g_bad_map
         $error("field map is fixed to the package register and address widths");
      end
   endgenerate

   logic              ctrl_hit;
   logic [IDX_W-1:0]  ctrl_idx;
   logic              stat0_hit;
   logic [FLAT_W-1:0] ctrl_flat;
   logic [P_REG_W-1:0] cr [NUM_CTRL];

   phyreg_addr_dec #(
      .ADDR_W   (P_ADDR_W),
      .NUM_CTRL (NUM_CTRL),
      .IDX_W    (IDX_W),
      .STAT0    (STAT0_OFF)
   ) u_dec (
      .addr      (addr),
      .ctrl_hit  (ctrl_hit),
      .ctrl_idx  (ctrl_idx),
      .stat0_hit (stat0_hit)
   );

   generate
      for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
         logic we_i;
         assign we_i = wr_en && ctrl_hit && (ctrl_idx == IDX_W'(i));

         phyreg_wmask_cell #(
            .W   (P_REG_W),
            .RST (ctl_reset(i))
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_i),
            .mask  (wdata[P_BUS_W-1:P_REG_W]),
            .data  (wdata[P_REG_W-1:0]),
            .q     (ctrl_flat[i*P_REG_W +: P_REG_W])
         );

         assign cr[i] = ctrl_flat[i*P_REG_W +: P_REG_W];
      end
   endgenerate

   phyreg_rd_mux #(
      .REG_W     (P_REG_W),
      .BUS_W     (P_BUS_W),
      .NUM_CTRL  (NUM_CTRL),
      .IDX_W     (IDX_W),
      .READ_FLOP (READ_FLOP)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .ctrl_hit  (ctrl_hit),
      .ctrl_idx  (ctrl_idx),
      .stat0_hit (stat0_hit),
      .ctrl_flat (ctrl_flat),
      .pll_ready (pll_ready),
      .rdata     (rdata)
   );

   // power and clocking fields
   assign lane_idle  = cr[IX_PWR][8 +: P_NUM_LANES];
   assign lane_pwrdn = cr[IX_PWR][4 +: P_NUM_LANES];
   assign iddq_en    = cr[IX_PWR][1];
   assign pll_pwrdn  = cr[IX_PWR][0];
   assign pll_div    = cr[IX_PLLDIV][14:0];
   assign tx_term    = cr[IX_CLK][10:8];
   assign rate_sel   = cr[IX_CLK][5:4];
   assign ref_div    = cr[IX_CLK][3:0];

   // per-lane drive fields
   generate
      for (genvar n = 0; n < P_NUM_LANES; n++) begin : g_lane
         assign lane_emph[4*n +: 4]      = cr[IX_EMPH][4*n +: 4];
         assign lane_amp[3*n +: 3]       = cr[IX_AMP][4*n +: 3];
         assign lane_amp_scale[2*n +: 2] = cr[IX_SCALE][2*n +: 2];
      end
   endgenerate

   assign tx_mode   = cr[IX_SCALE][9:8];
   assign ssc_depth = cr[IX_SSC][15:12];
   assign ssc_en    = cr[IX_SSC][11];
   assign ssc_step  = cr[IX_SSC][9:0];
   assign spare_ctl = cr[IX_SPARE];
   assign pll_ctl   = cr[IX_PLLCTL];
   assign tx_ctl    = cr[IX_TXCTL];

   // auxiliary channel fields
   assign aux_rcv_pd_sel = cr[IX_AUXPWR][5];
   assign aux_drv_pd_sel = cr[IX_AUXPWR][4];
   assign aux_idle       = cr[IX_AUXPWR][2];
   assign aux_rcv_pd     = cr[IX_AUXPWR][1];
   assign aux_drv_pd     = cr[IX_AUXPWR][0];
   assign aux_vcm        = cr[IX_AUXCFG][14:12];
   assign aux_mode       = cr[IX_AUXCFG][11:10];
   assign aux_amp_scale  = cr[IX_AUXCFG][9:8];
   assign aux_amp        = cr[IX_AUXCFG][6:4];
   assign aux_rterm      = cr[IX_AUXCFG][2:0];

   // R6
   ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ctrl_hit) |=> $stable(ctrl_flat));

   // R8
   rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && ctrl_hit && READ_FLOP) |=>
         rdata[P_REG_W-1:0] == $past(u_rd.sel_word));

endmodule

// File: tb/phyreg_bank_test.sv
`timescale 1ns/1ps
module phyreg_bank_test;

   localparam int FW = 153;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pll_ready = 1'b0;

   logic [3:0]  lane_idle, lane_pwrdn;
   logic        iddq_en, pll_pwrdn;
   logic [14:0] pll_div;
   logic [3:0]  ref_div;
   logic [1:0]  rate_sel;
   logic [2:0]  tx_term;
   logic [15:0] lane_emph;
   logic [11:0] lane_amp;
   logic [7:0]  lane_amp_scale;
   logic [1:0]  tx_mode;
   logic [3:0]  ssc_depth;
   logic        ssc_en;
   logic [9:0]  ssc_step;
   logic [15:0] spare_ctl, pll_ctl, tx_ctl;
   logic        aux_rcv_pd_sel, aux_drv_pd_sel, aux_idle, aux_rcv_pd, aux_drv_pd;
   logic [2:0]  aux_vcm;
   logic [1:0]  aux_mode, aux_amp_scale;
   logic [2:0]  aux_amp, aux_rterm;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;

   always #10 clk = ~clk;

   phyreg_bank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pll_ready(pll_ready),
      .lane_idle(lane_idle), .lane_pwrdn(lane_pwrdn), .iddq_en(iddq_en),
      .pll_pwrdn(pll_pwrdn), .pll_div(pll_div), .ref_div(ref_div),
      .rate_sel(rate_sel), .tx_term(tx_term), .lane_emph(lane_emph),
      .lane_amp(lane_amp), .lane_amp_scale(lane_amp_scale), .tx_mode(tx_mode),
      .ssc_depth(ssc_depth), .ssc_en(ssc_en), .ssc_step(ssc_step),
      .spare_ctl(spare_ctl), .pll_ctl(pll_ctl), .tx_ctl(tx_ctl),
      .aux_rcv_pd_sel(aux_rcv_pd_sel), .aux_drv_pd_sel(aux_drv_pd_sel),
      .aux_idle(aux_idle), .aux_rcv_pd(aux_rcv_pd), .aux_drv_pd(aux_drv_pd),
      .aux_vcm(aux_vcm), .aux_mode(aux_mode), .aux_amp_scale(aux_amp_scale),
      .aux_amp(aux_amp), .aux_rterm(aux_rterm)
   );

   // behavioural reference model
   logic [15:0] m [12];
   logic [31:0] m_rdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 12; k++) m[k] = 16'h0000;
         m[0]    = 16'h0FF1;
         m_rdata = 32'h0;
      end else begin
         if (rd_en) begin
            if (addr % 4 == 0 && addr / 4 < 12) m_rdata = {16'h0, m[addr / 4]};
            else if (addr == 8'h30)             m_rdata = {31'h0, pll_ready};
            else                                m_rdata = 32'h0;
         end
         if (wr_en && addr % 4 == 0 && addr / 4 < 12)
            m[addr / 4] = (m[addr / 4] & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);
      end
   end

   function automatic logic [FW-1:0] exp_fields();
      return {m[0][11:8], m[0][7:4], m[0][1], m[0][0], m[1][14:0], m[2][3:0],
              m[2][5:4], m[2][10:8], m[3],
              m[4][14:12], m[4][10:8], m[4][6:4], m[4][2:0],
              m[5][7:0], m[5][9:8], m[6][15:12], m[6][11], m[6][9:0],
              m[7], m[8], m[9], m[10][5], m[10][4], m[10][2], m[10][1], m[10][0],
              m[11][14:12], m[11][11:10], m[11][9:8], m[11][6:4], m[11][2:0]};
   endfunction

   logic [FW-1:0] act_fields;
   assign act_fields = {lane_idle, lane_pwrdn, iddq_en, pll_pwrdn, pll_div, ref_div,
                        rate_sel, tx_term, lane_emph, lane_amp, lane_amp_scale,
                        tx_mode, ssc_depth, ssc_en, ssc_step, spare_ctl, pll_ctl,
                        tx_ctl, aux_rcv_pd_sel, aux_drv_pd_sel, aux_idle, aux_rcv_pd,
                        aux_drv_pd, aux_vcm, aux_mode, aux_amp_scale, aux_amp, aux_rterm};

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (live && rst_n) begin
         checks++;
         if (act_fields !== exp_fields()) begin
            errors++;
            $display("FAIL R4 field outputs actual %h expected %h", act_fields, exp_fields());
         end
         checks++;
         if (rdata !== m_rdata) begin
            errors++;
            $display("FAIL R7 read data actual %h expected %h", rdata, m_rdata);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk(tag, rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live  = 1'b1;

      // R3 reset image
      bus_rd(8'h00, 32'h0000_0FF1, "R3 power reg reset");
      bus_rd(8'h04, 32'h0000_0000, "R3 divider reg reset");
      chk("R3 lane power-down reset", 32'(lane_pwrdn), 32'hF);

      // R1 mask selects only the lane idle bits
      bus_wr(8'h00, 32'h0F00_0000);
      bus_rd(8'h00, 32'h0000_00F1, "R1 idle bits cleared only");

      // R4 full-mask emphasis, then R1 single nibble
      bus_wr(8'h0C, 32'hFFFF_A5C3);
      chk("R4 lane emphasis", 32'(lane_emph), 32'h0000_A5C3);
      bus_wr(8'h0C, 32'h00F0_FFFF);
      chk("R1 nibble mask", 32'(lane_emph), 32'h0000_A5F3);

      // R4 amplitude packing
      bus_wr(8'h10, 32'hFFFF_7654);
      chk("R4 lane amplitude", 32'(lane_amp), 32'h0000_0FAC);

      // R1 zero mask
      bus_wr(8'h24, 32'h0000_FFFF);
      bus_rd(8'h24, 32'h0000_0000, "R1 zero mask");

      // R6 writes to status, out-of-range and misaligned offsets
      bus_wr(8'h30, 32'hFFFF_FFFF);
      bus_wr(8'h34, 32'hFFFF_FFFF);
      bus_wr(8'h3C, 32'hFFFF_FFFF);
      bus_wr(8'h05, 32'hFFFF_FFFF);
      bus_wr(8'hFC, 32'hFFFF_FFFF);
      bus_rd(8'h04, 32'h0000_0000, "R6 misaligned write dropped");
      chk("R6 divider output untouched", 32'(pll_div), 32'h0);

      // R5 status
      bus_rd(8'h30, 32'h0000_0000, "R5 pll not ready");
      @(negedge clk) pll_ready = 1'b1;
      bus_rd(8'h30, 32'h0000_0001, "R5 pll ready");
      bus_rd(8'h34, 32'h0000_0000, "R5 second status zero");

      // R7 unmapped and misaligned reads
      bus_rd(8'h40, 32'h0000_0000, "R7 unmapped read");
      bus_rd(8'h0E, 32'h0000_0000, "R7 misaligned read");

      // R8 read racing a write
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1; addr = 8'h08; wdata = 32'hFFFF_1234;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R8 old value on collision", rdata, 32'h0000_0000);
      bus_rd(8'h08, 32'h0000_1234, "R8 new value afterwards");

      // R2 every register stores and returns all bits
      for (int i = 0; i < 12; i++)
         bus_wr(8'(4 * i), {16'hFFFF, 16'(16'h1111 * (i + 1))});
      for (int i = 0; i < 12; i++)
         bus_rd(8'(4 * i), {16'h0, 16'(16'h1111 * (i + 1))}, "R2 readback");

      // R4 auxiliary fields
      bus_wr(8'h28, 32'hFFFF_0025);
      chk("R4 aux power bits", {27'h0, aux_rcv_pd_sel, aux_drv_pd_sel, aux_idle,
          aux_rcv_pd, aux_drv_pd}, 32'h0000_0015);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 50000);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule